// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects thirty-two level-sensitive interrupt request lines, which may change at any time with respect to the bus clock, and drives two interrupt outputs toward a processor. One output is a fast request (FIQ) and the other is a normal request (IRQ). Software programs the block through a small word-addressed register port. Through that port it sets per-source enables, picks which sources drive the fast output, and sets or clears software-forced requests. It also fills sixteen vector slots, each binding one source number to a service routine address, and reads back raw, masked and fast-routed status.

Priority is fixed. Enabled fast-routed sources come first and appear only on FIQ. The vector slots come next, with lower slot index winning. Any other enabled pending source is last and raises IRQ without a vector. Software reads the vector-address register to get the routine address of the winning slot, or a programmable default address when no slot is active. Reading it changes nothing. A hardware request is cleared by its own peripheral lowering the line.

Register port: word address bits [7:4] choose a region and bits [3:0] choose a word inside it. Region 0 holds the core registers, region 1 the slot control words and region 2 the slot addresses. Read data is registered and valid in the cycle after `bus_rd`. Unmapped reads return zero.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Raw status (address 0x00) reads as the synchronized request lines ORed with the software request register, with bit n belonging to source n.
- R2: Requests are levels and are not latched. Once a line falls, and no software request holds that bit, the source leaves raw status and stops driving the outputs.
- R3: Each request line passes two synchronizer flops. A line raised before clock edge 1 first shows on the output after edge 3 and is not yet visible after edge 2.
- R4: A source whose enable bit (address 0x03) is zero drives neither output and reads as zero in masked status.
- R5: `fiq_o` is the registered OR of the enabled pending sources whose fast-route bit (address 0x04) is one. `irq_o` is the registered OR of the other enabled pending sources.
- R6: Writing address 0x05 sets every software request bit given as a one, and a read of 0x05 returns the software request register. Writing address 0x06 clears every software request bit given as a one.
- R7: The slot n control word at 0x10+n holds the source number in bits [4:0] and the slot enable in bit 5. The slot n routine address is at 0x20+n. A slot is active when it is enabled and its source is pending, enabled and not fast-routed.
- R8: The vector address (0x07) returns the routine address of the active slot with the lowest index. When no slot is active it returns the default address register (0x08).
- R9: Masked status (0x01) equals raw status ANDed with the enables. Fast status (0x02) equals masked status ANDed with the fast-route bits.
- R10: Reading any register, the vector address included, changes neither the outputs nor any register value.
- R11: After synchronous reset every register, `bus_rdata`, `fiq_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Level interrupt request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after bus_rd |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
A single source can be fast-routed and also bound to a vector slot, so the fast path and vector selection must be judged together. The bench builds these overlaps on purpose, both as directed cases and by drawing fast-route bits and slot sources at random, and it expects the slot to be skipped while FIQ rises. A software-forced request can also land in the same cycle as a hardware level on the same bit. The bench mixes both kinds of request and judges the outputs and every status word against a model computed from the requirements.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // Region selector: upper address nibble
  localparam logic [3:0] RGN_CORE    = 4'h0;
  localparam logic [3:0] RGN_SLOTCTL = 4'h1;
  localparam logic [3:0] RGN_SLOTADR = 4'h2;

  // Word offsets inside the core region
  localparam logic [3:0] OFF_RAW    = 4'h0;
  localparam logic [3:0] OFF_MASKED = 4'h1;
  localparam logic [3:0] OFF_FIQST  = 4'h2;
  localparam logic [3:0] OFF_EN     = 4'h3;
  localparam logic [3:0] OFF_FSEL   = 4'h4;
  localparam logic [3:0] OFF_SSET   = 4'h5;
  localparam logic [3:0] OFF_SCLR   = 4'h6;
  localparam logic [3:0] OFF_VADDR  = 4'h7;
  localparam logic [3:0] OFF_DFLT   = 4'h8;
endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC-1:0]        fiqsel,
  input  logic [NSLOT-1:0]       slot_en,
  input  logic [NSLOT*SEL_W-1:0] slot_src,
  input  logic [NSLOT*DW-1:0]    slot_addr,
  input  logic [DW-1:0]          dflt,
  output logic                   hit,
  output logic [DW-1:0]          vaddr
);
  logic [NSLOT-1:0] act;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [SEL_W-1:0] s;
    assign s      = slot_src[g*SEL_W +: SEL_W];
    assign act[g] = slot_en[g] & pend[s] & ~fiqsel[s];
  end

  // Lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    hit   = 1'b0;
    vaddr = dflt;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (act[i]) begin
        hit   = 1'b1;
        vaddr = slot_addr[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_src_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            fiq_o,
  output logic            irq_o
);
  localparam int SEL_W  = $clog2(NSRC);
  localparam int SIDX_W = $clog2(NSLOT);

  logic [NSRC-1:0]  sync_q;
  logic [NSRC-1:0]  en_q, fsel_q, soft_q;
  logic [DW-1:0]    dflt_q;
  logic [NSLOT-1:0] slot_en_q;
  logic [SEL_W-1:0] slot_src_q  [NSLOT];
  logic [DW-1:0]    slot_addr_q [NSLOT];

  logic [NSLOT*SEL_W-1:0] slot_src_flat;
  logic [NSLOT*DW-1:0]    slot_addr_flat;

  logic [NSRC-1:0] raw, pend;
  logic            vec_hit;
  logic [DW-1:0]   vec_addr;
  logic [DW-1:0]   rd_mux;

  logic [3:0]        rgn;
  logic [3:0]        off;
  logic [SIDX_W-1:0] sidx;
  logic              slot_ok;

  assign rgn     = bus_addr[7:4];
  assign off     = bus_addr[3:0];
  assign sidx    = off[SIDX_W-1:0];
  assign slot_ok = (int'(off) < NSLOT);

  ivc_sync #(.W(NSRC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_src_i),
    .q   (sync_q)
  );

  assign raw  = sync_q | soft_q;
  assign pend = raw & en_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign slot_src_flat[g*SEL_W +: SEL_W] = slot_src_q[g];
    assign slot_addr_flat[g*DW +: DW]      = slot_addr_q[g];
  end

  ivc_pick #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_pick (
    .pend      (pend),
    .fiqsel    (fsel_q),
    .slot_en   (slot_en_q),
    .slot_src  (slot_src_flat),
    .slot_addr (slot_addr_flat),
    .dflt      (dflt_q),
    .hit       (vec_hit),
    .vaddr     (vec_addr)
  );

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      fsel_q    <= '0;
      soft_q    <= '0;
      dflt_q    <= '0;
      slot_en_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slot_src_q[i]  <= '0;
        slot_addr_q[i] <= '0;
      end
    end else if (bus_wr) begin
      if (rgn == RGN_CORE) begin
        case (off)
          OFF_EN:   en_q   <= bus_wdata[NSRC-1:0];
          OFF_FSEL: fsel_q <= bus_wdata[NSRC-1:0];
          OFF_SSET: soft_q <= soft_q | bus_wdata[NSRC-1:0];
          OFF_SCLR: soft_q <= soft_q & ~bus_wdata[NSRC-1:0];
          OFF_DFLT: dflt_q <= bus_wdata;
          default: ;
        endcase
      end else if (rgn == RGN_SLOTCTL && slot_ok) begin
        slot_en_q[sidx]  <= bus_wdata[SEL_W];
        slot_src_q[sidx] <= bus_wdata[SEL_W-1:0];
      end else if (rgn == RGN_SLOTADR && slot_ok) begin
        slot_addr_q[sidx] <= bus_wdata;
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    if (rgn == RGN_CORE) begin
      case (off)
        OFF_RAW:    rd_mux = DW'(raw);
        OFF_MASKED: rd_mux = DW'(pend);
        OFF_FIQST:  rd_mux = DW'(pend & fsel_q);
        OFF_EN:     rd_mux = DW'(en_q);
        OFF_FSEL:   rd_mux = DW'(fsel_q);
        OFF_SSET:   rd_mux = DW'(soft_q);
        OFF_VADDR:  rd_mux = vec_addr;
        OFF_DFLT:   rd_mux = dflt_q;
        default:    rd_mux = '0;
      endcase
    end else if (rgn == RGN_SLOTCTL && slot_ok) begin
      rd_mux = DW'({slot_en_q[sidx], slot_src_q[sidx]});
    end else if (rgn == RGN_SLOTADR && slot_ok) begin
      rd_mux = slot_addr_q[sidx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      fiq_o     <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      fiq_o <= |(pend & fsel_q);
      irq_o <= |(pend & ~fsel_q);
    end
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] fsel_q,
  input logic [NSRC-1:0] soft_q,
  input logic [NSRC-1:0] raw,
  input logic [NSRC-1:0] pend,
  input logic            vec_hit,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            fiq_o,
  input logic            irq_o
);
  localparam logic [AW-1:0] SCLR_A = AW'({RGN_CORE, OFF_SCLR});

  // R4: with every source masked, neither output rises next cycle
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (!fiq_o && !irq_o));

  // R9: masked status never shows a bit absent from raw status
  a_r9_masked_subset: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~raw) == '0));

  // R7: an active vector slot implies a pending non-fast source
  a_r7_slot_is_irq: assert property (@(posedge clk) disable iff (rst)
    vec_hit |-> (|(pend & ~fsel_q)));

  // R6: bits written to the clear register are gone next cycle
  a_r6_soft_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == SCLR_A) |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == '0));

  // R5: a fast-routed pending source forces fiq_o next cycle
  a_r5_fiq_follows: assert property (@(posedge clk) disable iff (rst)
    (|(pend & fsel_q)) |=> fiq_o);
endmodule

bind irq_vector_ctrl ivc_checker #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .fsel_q    (fsel_q),
  .soft_q    (soft_q),
  .raw       (raw),
  .pend      (pend),
  .vec_hit   (vec_hit),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .fiq_o     (fiq_o),
  .irq_o     (irq_o)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NSLOT = 16;
  localparam logic [7:0] A_RAW = 8'h00, A_MSK = 8'h01, A_FST = 8'h02, A_EN = 8'h03,
                         A_FSEL = 8'h04, A_SSET = 8'h05, A_SCLR = 8'h06,
                         A_VEC = 8'h07, A_DFLT = 8'h08;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] hw;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fiq_o, irq_o;

  int total = 0;
  int bad   = 0;

  // Model state
  logic [31:0] m_en, m_fsel, m_soft, m_dflt;
  logic        m_sen  [NSLOT];
  logic [4:0]  m_ssrc [NSLOT];
  logic [31:0] m_sadr [NSLOT];

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk       (clk),
    .rst       (rst),
    .irq_src_i (hw),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fiq_o     (fiq_o),
    .irq_o     (irq_o)
  );

  function automatic logic [31:0] e_raw();
    return hw | m_soft;
  endfunction
  function automatic logic [31:0] e_pend();
    return (hw | m_soft) & m_en;
  endfunction
  function automatic logic [31:0] e_vec();
    logic [31:0] p = (hw | m_soft) & m_en;
    for (int i = 0; i < NSLOT; i++)
      if (m_sen[i] && p[m_ssrc[i]] && !m_fsel[m_ssrc[i]]) return m_sadr[i];
    return m_dflt;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    case (a[7:4])
      4'h0: case (a[3:0])
              4'h3: m_en   = d;
              4'h4: m_fsel = d;
              4'h5: m_soft = m_soft | d;
              4'h6: m_soft = m_soft & ~d;
              4'h8: m_dflt = d;
              default: ;
            endcase
      4'h1: begin m_sen[a[3:0]] = d[5]; m_ssrc[a[3:0]] = d[4:0]; end
      4'h2: m_sadr[a[3:0]] = d;
      default: ;
    endcase
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic full_check(string tag);
    logic [31:0] v;
    check({tag, " R5 fiq"}, 32'(fiq_o), 32'(|(e_pend() & m_fsel)));
    check({tag, " R5 irq"}, 32'(irq_o), 32'(|(e_pend() & ~m_fsel)));
    rreg(A_RAW, v); check({tag, " R1 raw"}, v, e_raw());
    rreg(A_MSK, v); check({tag, " R9 masked"}, v, e_pend());
    rreg(A_FST, v); check({tag, " R9 fast"}, v, e_pend() & m_fsel);
    rreg(A_VEC, v); check({tag, " R8 vector"}, v, e_vec());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    logic        i0;
    void'($urandom(32'd1234));
    rst = 1'b1; hw = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_en = '0; m_fsel = '0; m_soft = '0; m_dflt = '0;
    for (int i = 0; i < NSLOT; i++) begin m_sen[i] = 1'b0; m_ssrc[i] = '0; m_sadr[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 fiq", 32'(fiq_o), 0);
    check("R11 irq", 32'(irq_o), 0);
    check("R11 rdata", bus_rdata, 0);
    rreg(A_EN, v);       check("R11 enable", v, 0);
    rreg(A_RAW, v);      check("R11 raw", v, 0);
    rreg(8'h13, v);      check("R11 slot ctl", v, 0);
    rreg(A_VEC, v);      check("R11 vector", v, 0);

    // R3 synchronizer latency
    wreg(A_EN, 32'hFFFF_FFFF);
    @(negedge clk); hw = 32'h0000_0008;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 not yet after edge 2", 32'(irq_o), 0);
    @(posedge clk); @(negedge clk);
    check("R3 visible after edge 3", 32'(irq_o), 1);

    // R2 level: drop line
    hw = '0; settle();
    check("R2 irq drops", 32'(irq_o), 0);
    rreg(A_RAW, v); check("R2 raw clears", v, 0);

    // R4 masked sources
    wreg(A_EN, 32'h0); wreg(A_FSEL, 32'h0000_00F0);
    hw = 32'hFFFF_FFFF; settle();
    check("R4 irq masked", 32'(irq_o), 0);
    check("R4 fiq masked", 32'(fiq_o), 0);
    rreg(A_MSK, v); check("R4 masked status", v, 0);
    rreg(A_RAW, v); check("R1 raw unmasked", v, 32'hFFFF_FFFF);
    hw = '0;

    // R6 software set/clear
    wreg(A_SSET, 32'h8000_0011); wreg(A_SSET, 32'h0000_0100);
    rreg(A_SSET, v); check("R6 soft set", v, 32'h8000_0111);
    wreg(A_SCLR, 32'h0000_0011);
    rreg(A_SSET, v); check("R6 soft clear", v, 32'h8000_0100);
    wreg(A_EN, 32'h8000_0000); wreg(A_FSEL, 32'h8000_0000); settle();
    check("R5 soft to fiq", 32'(fiq_o), 1);
    check("R5 soft no irq", 32'(irq_o), 0);
    wreg(A_SCLR, 32'hFFFF_FFFF); settle();
    check("R6 fiq gone", 32'(fiq_o), 0);

    // R7/R8 slot priority, fast override, default
    wreg(A_DFLT, 32'hDEF0_0000);
    wreg(8'h10, 32'h20 | 32'd9);  wreg(8'h20, 32'hA000_0000);
    wreg(8'h15, 32'h20 | 32'd12); wreg(8'h25, 32'hA000_0500);
    rreg(8'h15, v); check("R7 slot ctl readback", v, 32'h2C);
    wreg(A_EN, 32'hFFFF_FFFF); wreg(A_FSEL, 32'h0);
    hw = (32'h1 << 9) | (32'h1 << 12); settle();
    rreg(A_VEC, v); check("R8 lowest slot wins", v, 32'hA000_0000);
    wreg(A_FSEL, 32'h1 << 9); settle();
    rreg(A_VEC, v); check("R7 fast source skips slot", v, 32'hA000_0500);
    check("R5 fiq and irq together", 32'(fiq_o & irq_o), 1);
    wreg(8'h15, 32'd12); settle();
    rreg(A_VEC, v); check("R7 disabled slot gives default", v, 32'hDEF0_0000);

    // R10 reads are side-effect free
    i0 = irq_o;
    rreg(A_VEC, v); rreg(A_VEC, v2);
    check("R10 vector stable", v2, v);
    check("R10 irq unchanged", 32'(irq_o), 32'(i0));
    rreg(A_SSET, v); check("R10 soft unchanged", v, 0);
    hw = '0;

    // Random mix
    for (int it = 0; it < 60; it++) begin
      for (int s = 0; s < NSLOT; s++) begin
        if ($urandom % 3 == 0) begin
          wreg(8'(8'h10 + s), ($urandom & 32'h20) | ($urandom % 32));
          wreg(8'(8'h20 + s), $urandom);
        end
      end
      wreg(A_EN, $urandom | $urandom);
      wreg(A_FSEL, $urandom & $urandom & $urandom);
      wreg(A_DFLT, $urandom);
      if ($urandom % 2 == 0) wreg(A_SSET, $urandom & $urandom & $urandom);
      else                   wreg(A_SCLR, $urandom);
      hw = $urandom & $urandom & $urandom;
      settle();
      full_check("rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule